// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped controller for a bank-organised array of one-time-programmable 32-bit fuse words. Each fuse word has a shadow register beside it. After reset the controller copies the fuse array into the shadows. Software can then read the shadows directly or overwrite them, and these overrides never touch the fuses. To reach the fuse array itself, software uses two timed operations. A sense copies one fuse word into a read-data register. A program operation ORs a data word into one fuse word. Programming runs only when a 16-bit unlock key is present in the control register.

Each timed operation is run by a small sequencer. It has five named states. `ST_BOOT` copies one word per cycle into the shadows after reset. `ST_IDLE` waits for a trigger. `ST_RELAX_A`, `ST_STROBE` and `ST_RELAX_B` form the relax, strobe and relax phases of a sense or program. The transitions are:
- BOOT to IDLE after the last word is copied.
- IDLE to RELAX_A on an accepted trigger.
- RELAX_A to STROBE when the relax count is reached.
- STROBE to RELAX_B when the read-strobe or program-strobe count is reached.
- RELAX_B to IDLE when the relax count is reached. This last transition also applies the result.

The busy flag is high in every state except IDLE. A request that cannot be carried out is refused and sets a sticky error flag.

The word address is the bank number times eight plus the word index. The bus is a simple one, with one write per cycle and reads decoded combinationally. These are the register offsets:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x01 | control clear-alias |
| 0x02 | timing |
| 0x03 | read trigger |
| 0x04 | read data |
| 0x05 | program data |
| 0x80 + n | shadow word n |

Top module: `otp_fuse_ctrl`

## Requirements
- R1: From reset release, busy stays high for exactly NWORDS cycles (32 by default) while each shadow n is loaded from fuse word n. At reset, fuse word n holds SEED ^ (n * 0x01030507), with SEED = 0x5A3C0F00.
- R2: The control register reads as key in bits 31:16, error in bit 9, busy in bit 8 and word address in bits 6:0, with other bits reading 0. A write to it updates only the key and the address.
- R3: Writing to the clear-alias (offset 0x01) clears each key or address bit written as 1. A 1 in bit 9 clears the error flag. All other bits keep their value.
- R4: The timing register holds the read-strobe count in bits 21:16, the relax count in bits 15:12 and the program-strobe count in bits 11:0. Other bits read 0. Its reset value is 0x00021004.
- R5: Writing 1 to bit 0 of the read trigger starts a sense. Busy is then high for (relax+1)+(read_strobe+1)+(relax+1) cycles. Afterwards, read data holds the addressed fuse word.
- R6: With key 0x3E77, a write to program data starts a program. Busy is then high for (relax+1)+(prog_strobe+1)+(relax+1) cycles. The fuse word becomes its old value ORed with the data, and the key reads 0 afterwards.
- R7: A program-data write with any other key sets the error flag, starts nothing and leaves the fuses unchanged.
- R8: While busy, a sense trigger, a program write, a timing write or a shadow write is refused. The refusal sets the error flag, and the operation already running completes normally.
- R9: A sense or program trigger with a word address of NWORDS or more sets the error flag and starts nothing. A shadow access at such an index also sets the error flag, and a read there returns 0.
- R10: Shadow writes change the shadow readback and leave the fuse unchanged. Programming leaves the shadow unchanged.
- R11: A read-trigger write with bit 0 clear has no effect.
- R12: Word address bank*8+word selects fuse word number bank*8+word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset (bit 7 selects shadow window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| busy_o | output | 1 | Sequencer busy (same as control bit 8) |

## Verification
The patterns are chosen so that each one separates one behaviour from its neighbours:
- The sense is run twice with different timing values. This shows that busy length follows the relax and strobe fields and does not depend on fixed counts.
- Programming is tried on a word whose set bits partly overlap the data. This distinguishes an OR update from a plain overwrite.
- Programming is also tried with a wrong key, at an out-of-range address and while busy. These distinguish refusals from accepted operations.
- Shadow overrides are followed by a sense of the same word. This shows that the shadow and the fuse are stored separately.

A behavioural reference model checks busy and the addressed readback on every clock.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_RELAX_A,
        ST_STROBE,
        ST_RELAX_B
    } seq_state_t;

    localparam int          BUS_AW        = 8;
    localparam int          RELAX_W       = 4;
    localparam int          RD_STB_W      = 6;
    localparam int          PG_STB_W      = 12;
    localparam int          KEY_W         = 16;
    localparam int          WADDR_W       = 7;
    localparam int          WORDS_PER_BNK = 8;

    localparam logic [BUS_AW-1:0] OFS_CTRL      = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_CTRL_CLR  = 8'h01;
    localparam logic [BUS_AW-1:0] OFS_TIMING    = 8'h02;
    localparam logic [BUS_AW-1:0] OFS_RD_TRIG   = 8'h03;
    localparam logic [BUS_AW-1:0] OFS_RD_DATA   = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_PG_DATA   = 8'h05;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY    = 16'h3E77;
    localparam int                ERR_BIT       = 9;

endpackage

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int NWORDS = 32,
    parameter int IDX_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 prog_i,
    input  logic [RELAX_W-1:0]   relax_i,
    input  logic [RD_STB_W-1:0]  rd_stb_i,
    input  logic [PG_STB_W-1:0]  pg_stb_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 done_prog_o,
    output logic                 boot_we_o,
    output logic [IDX_W-1:0]     boot_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    seq_state_t            state_q, state_d;
    logic [PG_STB_W-1:0]   cnt_q, cnt_d;
    logic                  prog_q, prog_d;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic [PG_STB_W-1:0]   relax_lim, stb_lim;

    assign relax_lim = PG_STB_W'(relax_i);
    assign stb_lim   = prog_q ? pg_stb_i : PG_STB_W'(rd_stb_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
            prog_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prog_q  <= prog_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        prog_d  = prog_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_BOOT: begin
                idx_d = idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                cnt_d = '0;
                if (start_i) begin
                    state_d = ST_RELAX_A;
                    prog_d  = prog_i;
                end
            end
            ST_RELAX_A: begin
                if (cnt_q == relax_lim) begin
                    state_d = ST_STROBE;
                    cnt_d   = '0;
                end
            end
            ST_STROBE: begin
                if (cnt_q == stb_lim) begin
                    state_d = ST_RELAX_B;
                    cnt_d   = '0;
                end
            end
            ST_RELAX_B: begin
                if (cnt_q == relax_lim) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        boot_we_o   = (state_q == ST_BOOT);
        boot_idx_o  = idx_q;
        done_o      = (state_q == ST_RELAX_B) && (cnt_q == relax_lim);
        done_prog_o = done_o && prog_q;
    end

endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int          NWORDS = 32,
    parameter int          IDX_W  = 5,
    parameter logic [31:0] SEED   = 32'h5A3C_0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_we_i,
    input  logic [IDX_W-1:0]  boot_idx_i,
    input  logic              prog_we_i,
    input  logic [IDX_W-1:0]  prog_idx_i,
    input  logic [31:0]       prog_data_i,
    input  logic              sh_we_i,
    input  logic [IDX_W-1:0]  sh_idx_i,
    input  logic [31:0]       sh_data_i,
    input  logic [IDX_W-1:0]  sense_idx_i,
    output logic [31:0]       sense_data_o,
    input  logic [IDX_W-1:0]  sh_rd_idx_i,
    output logic [31:0]       sh_rd_data_o
);

    function automatic logic [31:0] fuse_init(input int n);
        return SEED ^ (32'(n) * 32'h0103_0507);
    endfunction

    logic [31:0] fuse_q   [NWORDS];
    logic [31:0] shadow_q [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) begin
                fuse_q[w]   <= fuse_init(w);
                shadow_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (prog_we_i && (prog_idx_i == IDX_W'(w))) begin
                    fuse_q[w] <= fuse_q[w] | prog_data_i;
                end
                if (boot_we_i && (boot_idx_i == IDX_W'(w))) begin
                    shadow_q[w] <= fuse_q[w];
                end else if (sh_we_i && (sh_idx_i == IDX_W'(w))) begin
                    shadow_q[w] <= sh_data_i;
                end
            end
        end
    end

    assign sense_data_o = fuse_q[sense_idx_i];
    assign sh_rd_data_o = shadow_q[sh_rd_idx_i];

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int          NUM_BANKS = 4,
    parameter logic [31:0] SEED      = 32'h5A3C_0F00,
    parameter int          RELAX_RST = 1,
    parameter int          RD_RST    = 2,
    parameter int          PG_RST    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                busy_o
);

    localparam int NWORDS = NUM_BANKS * WORDS_PER_BNK;
    localparam int IDX_W  = $clog2(NWORDS);

    logic [KEY_W-1:0]    key_q;
    logic [WADDR_W-1:0]  addr_q;
    logic                err_q;
    logic [RELAX_W-1:0]  relax_q;
    logic [RD_STB_W-1:0] rd_stb_q;
    logic [PG_STB_W-1:0] pg_stb_q;
    logic [31:0]         rd_data_q;
    logic [IDX_W-1:0]    op_idx_q;
    logic [31:0]         op_data_q;

    logic        seq_busy, seq_done, seq_done_prog, boot_we;
    logic [IDX_W-1:0] boot_idx;
    logic [31:0] sense_data, sh_rd_data;

    logic wr_ctrl, wr_clr, wr_timing, wr_trig, wr_prog, wr_shadow;
    logic addr_ok, sh_ok, start_sense, start_prog, start_any, reject;
    logic [IDX_W-1:0] sh_idx;

    always_comb begin
        wr_ctrl     = bus_we && (bus_addr == OFS_CTRL);
        wr_clr      = bus_we && (bus_addr == OFS_CTRL_CLR);
        wr_timing   = bus_we && (bus_addr == OFS_TIMING);
        wr_trig     = bus_we && (bus_addr == OFS_RD_TRIG) && bus_wdata[0];
        wr_prog     = bus_we && (bus_addr == OFS_PG_DATA);
        wr_shadow   = bus_we && bus_addr[BUS_AW-1];
        addr_ok     = (32'(addr_q) < NWORDS);
        sh_ok       = (32'(bus_addr[WADDR_W-1:0]) < NWORDS);
        sh_idx      = bus_addr[IDX_W-1:0];
        start_sense = wr_trig && !seq_busy && addr_ok;
        start_prog  = wr_prog && !seq_busy && addr_ok && (key_q == UNLOCK_KEY);
        start_any   = start_sense || start_prog;
        reject      = (wr_trig && !start_sense)
                   || (wr_prog && !start_prog)
                   || (wr_timing && seq_busy)
                   || (wr_shadow && (seq_busy || !sh_ok));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q     <= '0;
            addr_q    <= '0;
            err_q     <= 1'b0;
            relax_q   <= RELAX_W'(RELAX_RST);
            rd_stb_q  <= RD_STB_W'(RD_RST);
            pg_stb_q  <= PG_STB_W'(PG_RST);
            rd_data_q <= '0;
            op_idx_q  <= '0;
            op_data_q <= '0;
        end else begin
            if (seq_done && !seq_done_prog) begin
                rd_data_q <= sense_data;
            end
            if (seq_done_prog) begin
                key_q <= '0;
            end
            if (wr_ctrl) begin
                key_q  <= bus_wdata[31:16];
                addr_q <= bus_wdata[WADDR_W-1:0];
            end
            if (wr_clr) begin
                key_q  <= key_q & ~bus_wdata[31:16];
                addr_q <= addr_q & ~bus_wdata[WADDR_W-1:0];
                if (bus_wdata[ERR_BIT]) begin
                    err_q <= 1'b0;
                end
            end
            if (wr_timing && !seq_busy) begin
                rd_stb_q <= bus_wdata[21:16];
                relax_q  <= bus_wdata[15:12];
                pg_stb_q <= bus_wdata[11:0];
            end
            if (start_any) begin
                op_idx_q  <= addr_q[IDX_W-1:0];
                op_data_q <= bus_wdata;
            end
            if (reject) begin
                err_q <= 1'b1;
            end
        end
    end

    otp_seq #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_any),
        .prog_i      (start_prog),
        .relax_i     (relax_q),
        .rd_stb_i    (rd_stb_q),
        .pg_stb_i    (pg_stb_q),
        .busy_o      (seq_busy),
        .done_o      (seq_done),
        .done_prog_o (seq_done_prog),
        .boot_we_o   (boot_we),
        .boot_idx_o  (boot_idx)
    );

    otp_store #(.NWORDS(NWORDS), .IDX_W(IDX_W), .SEED(SEED)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_we_i    (boot_we),
        .boot_idx_i   (boot_idx),
        .prog_we_i    (seq_done_prog),
        .prog_idx_i   (op_idx_q),
        .prog_data_i  (op_data_q),
        .sh_we_i      (wr_shadow && !reject),
        .sh_idx_i     (sh_idx),
        .sh_data_i    (bus_wdata),
        .sense_idx_i  (op_idx_q),
        .sense_data_o (sense_data),
        .sh_rd_idx_i  (sh_idx),
        .sh_rd_data_o (sh_rd_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[BUS_AW-1]) begin
            bus_rdata = sh_ok ? sh_rd_data : 32'h0;
        end else begin
            unique case (bus_addr)
                OFS_CTRL:    bus_rdata = {key_q, 6'b0, err_q, seq_busy, 1'b0, addr_q};
                OFS_TIMING:  bus_rdata = {10'b0, rd_stb_q, relax_q, pg_stb_q};
                OFS_RD_DATA: bus_rdata = rd_data_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign busy_o = seq_busy;

endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk
    import otp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               busy,
    input logic               done,
    input logic               done_prog,
    input logic               start,
    input logic [KEY_W-1:0]   key,
    input logic               err,
    input logic [31:0]        sense_data,
    input logic [31:0]        op_data
);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_prog && !(bus_we && bus_addr == OFS_CTRL)) |=> (key == '0));

    // R6
    fuse_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_prog |=> ((sense_data & $past(op_data)) == $past(op_data)));

    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_PG_DATA && key != UNLOCK_KEY) |=> err);

    // R3
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(bus_we && bus_addr == OFS_CTRL_CLR && bus_wdata[ERR_BIT]));

endmodule

bind otp_fuse_ctrl otp_fuse_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy_o),
    .done       (seq_done),
    .done_prog  (seq_done_prog),
    .start      (start_any),
    .key        (key_q),
    .err        (err_q),
    .sense_data (sense_data),
    .op_data    (op_data_q)
);

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;

    localparam int          NW   = 32;
    localparam logic [31:0] SEED = 32'h5A3C_0F00;
    localparam logic [7:0]  A_CTRL = 8'h00, A_CLR = 8'h01, A_TIM = 8'h02,
                            A_TRIG = 8'h03, A_RDAT = 8'h04, A_PROG = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    otp_fuse_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_o(busy_o)
    );

    function automatic logic [31:0] fuse_at(input int n);
        return SEED ^ (32'(n) * 32'h0103_0507);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model
    logic [31:0] m_fuse [NW];
    logic [31:0] m_sh   [NW];
    logic [15:0] m_key;
    logic [6:0]  m_addr;
    logic        m_err;
    int          m_relax, m_rds, m_pgs, m_left, m_mode, m_op;
    logic [31:0] m_rdat, m_opd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                m_fuse[i] = fuse_at(i);
                m_sh[i]   = 32'h0;
            end
            m_key = 0; m_addr = 0; m_err = 0;
            m_relax = 1; m_rds = 2; m_pgs = 4;
            m_rdat = 0; m_opd = 0; m_op = 0;
            m_left = NW; m_mode = 1;
        end else begin
            bit bsy;
            bsy = (m_left > 0);
            if (bsy) begin
                if (m_mode == 1) m_sh[NW - m_left] = m_fuse[NW - m_left];
                else if (m_left == 1) begin
                    if (m_mode == 3) begin
                        m_fuse[m_op] = m_fuse[m_op] | m_opd;
                        m_key = 0;
                    end else m_rdat = m_fuse[m_op];
                end
                m_left--;
            end
            if (bus_we) begin
                if (bus_addr[7]) begin
                    if (bsy || int'(bus_addr[6:0]) >= NW) m_err = 1;
                    else m_sh[bus_addr[6:0]] = bus_wdata;
                end else if (bus_addr == A_CTRL) begin
                    m_key = bus_wdata[31:16]; m_addr = bus_wdata[6:0];
                end else if (bus_addr == A_CLR) begin
                    m_key = m_key & ~bus_wdata[31:16];
                    m_addr = m_addr & ~bus_wdata[6:0];
                    if (bus_wdata[9]) m_err = 0;
                end else if (bus_addr == A_TIM) begin
                    if (bsy) m_err = 1;
                    else begin
                        m_rds = int'(bus_wdata[21:16]);
                        m_relax = int'(bus_wdata[15:12]);
                        m_pgs = int'(bus_wdata[11:0]);
                    end
                end else if (bus_addr == A_TRIG && bus_wdata[0]) begin
                    if (bsy || int'(m_addr) >= NW) m_err = 1;
                    else begin
                        m_op = int'(m_addr); m_mode = 2;
                        m_left = 2 * (m_relax + 1) + m_rds + 1;
                    end
                end else if (bus_addr == A_PROG) begin
                    if (bsy || m_key != 16'h3E77 || int'(m_addr) >= NW) m_err = 1;
                    else begin
                        m_op = int'(m_addr); m_mode = 3; m_opd = bus_wdata;
                        m_left = 2 * (m_relax + 1) + m_pgs + 1;
                    end
                end
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a[7]) return (int'(a[6:0]) < NW) ? m_sh[a[6:0]] : 32'h0;
        case (a)
            A_CTRL: return {m_key, 6'b0, m_err, (m_left > 0), 1'b0, m_addr};
            A_TIM:  return {10'b0, 6'(m_rds), 4'(m_relax), 12'(m_pgs)};
            A_RDAT: return m_rdat;
            default: return 32'h0;
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check32("R1/R5 busy", {31'b0, busy_o}, {31'b0, (m_left > 0)});
            if (bus_addr[7]) check32("R10 shadow readback", bus_rdata, exp_read(bus_addr));
            else if (bus_addr == A_CTRL) check32("R2 control readback", bus_rdata, exp_read(bus_addr));
            else if (bus_addr == A_TIM) check32("R4 timing readback", bus_rdata, exp_read(bus_addr));
            else check32("R5 data readback", bus_rdata, exp_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = A_CTRL; bus_wdata = 32'h0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check32(tag, bus_rdata, exp);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        count_busy(n);
        check32("R1 boot busy cycles", n, NW);
        rd_chk(8'h85, fuse_at(5), "R1 shadow 5 loaded");
        rd_chk(8'h80 + 8'(NW - 1), fuse_at(NW - 1), "R1 last shadow loaded");

        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk(A_CTRL, 32'hFFFF_007F, "R2 control fields");

        wr(A_CLR, 32'h0000_0003);
        rd_chk(A_CTRL, 32'hFFFF_007C, "R3 partial clear");
        wr(A_CLR, 32'hFFFF_FFFF);
        rd_chk(A_CTRL, 32'h0, "R3 full clear");

        rd_chk(A_TIM, 32'h0002_1004, "R4 timing reset");
        wr(A_TIM, 32'hFFFF_FFFF);
        rd_chk(A_TIM, 32'h003F_FFFF, "R4 timing masks");
        wr(A_TIM, (32'd3 << 16) | (32'd2 << 12) | 32'd6);
        rd_chk(A_TIM, 32'h0003_2006, "R4 timing set");

        wr(A_TRIG, 32'h0);
        check32("R11 no start", {31'b0, busy_o}, 32'h0);
        rd_chk(A_CTRL, 32'h0, "R11 no error");

        wr(A_CTRL, (32'd2 << 3) | 32'd5);
        wr(A_TRIG, 32'h1);
        count_busy(n);
        check32("R5 sense busy length", n, 10);
        rd_chk(A_RDAT, fuse_at(21), "R12 bank2 word5 sensed");

        wr(A_CTRL, {16'h3E77, 16'd21});
        wr(A_PROG, 32'h0000_F0F0);
        count_busy(n);
        check32("R6 program busy length", n, 13);
        rd_chk(A_CTRL, 32'h0000_0015, "R6 key cleared");
        wr(A_TRIG, 32'h1);
        count_busy(n);
        rd_chk(A_RDAT, fuse_at(21) | 32'h0000_F0F0, "R6 fuse ORed");
        rd_chk(8'h80 + 8'd21, fuse_at(21), "R10 shadow untouched by program");

        wr(A_CTRL, {16'h1234, 16'd3});
        wr(A_PROG, 32'hFFFF_FFFF);
        check32("R7 no program", {31'b0, busy_o}, 32'h0);
        rd_chk(A_CTRL, 32'h1234_0203, "R7 error set");
        wr(A_CLR, 32'h0000_0200);
        wr(A_TRIG, 32'h1);
        count_busy(n);
        rd_chk(A_RDAT, fuse_at(3), "R7 fuse unchanged");

        wr(A_CTRL, {16'h3E77, 16'd4});
        wr(A_PROG, 32'h0000_0001);
        wr(A_TRIG, 32'h1);
        wr(8'h84, 32'hDEAD_BEEF);
        wr(A_TIM, 32'h0);
        count_busy(n);
        rd_chk(A_CTRL, 32'h0000_0204, "R8 refusals flagged");
        rd_chk(8'h84, fuse_at(4), "R8 shadow write refused");
        rd_chk(A_TIM, 32'h0003_2006, "R8 timing write refused");
        wr(A_CLR, 32'h0000_0200);
        wr(A_TRIG, 32'h1);
        count_busy(n);
        rd_chk(A_RDAT, fuse_at(4) | 32'h1, "R8 running program completed");

        wr(A_CTRL, 32'd40);
        wr(A_TRIG, 32'h1);
        check32("R9 no start out of range", {31'b0, busy_o}, 32'h0);
        rd_chk(A_CTRL, 32'h0000_0228, "R9 error on address");
        wr(A_CLR, 32'h0000_0200);
        wr(8'h80 + 8'd100, 32'h5);
        rd_chk(A_CTRL, 32'h0000_0228, "R9 error on shadow index");
        rd_chk(8'h80 + 8'd100, 32'h0, "R9 out-of-range shadow reads 0");
        wr(A_CLR, 32'h0000_0200);

        wr(8'h87, 32'hCAFE_F00D);
        rd_chk(8'h87, 32'hCAFE_F00D, "R10 shadow override");
        wr(A_CTRL, 32'd7);
        wr(A_TRIG, 32'h1);
        count_busy(n);
        rd_chk(A_RDAT, fuse_at(7), "R10 fuse kept after override");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule